// File: doc/BRIEF.md
# Breakpoint Debug Register File

This block holds the debug state of one processor core: a bank of breakpoint address registers, a sticky status word and a control word. Privileged software reaches them through a request channel. Each request carries a three-bit register index, a write flag, write data and the current privilege level of the requester. Every accepted request returns exactly one response one cycle later. The response carries the read data and two fault flags. One flag is a protection fault, raised when the privilege level is not zero. The other is a debug trap, raised when general-detect is armed.

A separate address-match unit drives single-cycle strobes into the block: breakpoint hits, single-step, task-trap and bus-lock. The block folds these strobes into the status word. A task-switch strobe clears the per-task (local) enables and leaves the global enables as they are. The block drives the full address bank and the control word out to the match unit.

The request channel uses valid/ready, and the block never applies back-pressure: `req_ready` is held high, so every cycle with `req_valid` high is one accepted request. The response has no ready. The requester must take `rsp_valid` in the cycle it is high.

Top module: `dbg_regfile`

## Requirements
- R1: An accepted request whose privilege level is not 0 changes no register. Its response has `rsp_gp_fault`=1, `rsp_db_trap`=0 and `rsp_rdata`=0. This check has priority over the general-detect trap.
- R2: Index 4 reads and writes the status register exactly as index 6 does. Index 5 reads and writes the control register exactly as index 7 does.
- R3: Control bits 0, 2, 4 and 6 are the local enables of breakpoints 0..3, and bits 1, 3, 5 and 7 are their global enables. A task-switch strobe clears only the local enables. It wins over a control write in the same cycle.
- R4: If control bit 13 is set, a privileged access does not complete. Instead the block sets status bit 13 and clears control bit 13, and the response has `rsp_db_trap`=1 and `rsp_rdata`=0.
- R5: A strobe on `bp_hit[n]` sets status bit n (n = 0..3), and the bit stays set until software writes it. If a hit and a status write arrive in the same cycle, the hit wins.
- R6: The `step_evt` strobe sets status bit 14 and the `task_trap_evt` strobe sets status bit 15. Status bits 13..15 are never cleared by hardware, and a software write sets or clears them directly.
- R7: Control bit 10 always reads 1. Control bits 11, 12, 14 and 15 always read 0, whatever was written. Bits 8 and 9 hold the value written.
- R8: Status bits 31:16 and 10:4 always read 1, and status bit 12 always reads 0.
- R9: The `bus_lock_evt` strobe clears status bit 11. Otherwise only a software write changes that bit, and the strobe wins over a write in the same cycle.
- R10: After reset, every address register reads 0, control reads 0x0000_0400 and status reads 0xFFFF_07F0.
- R11: Indices 0..3 are full 32-bit address registers. A response follows each accepted request by exactly one cycle. A write returns `rsp_rdata`=0, and `req_ready` is always 1.
- R12: For breakpoint n, control bits 17+4n:16+4n hold the condition and bits 19+4n:18+4n hold the length. These fields read back as written, and `ctl_word` always equals the control value that a read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | 3 | Register index 0..7 |
| req_wdata | input | 32 | Write data |
| req_cpl | input | 2 | Current privilege level of the requester |
| rsp_valid | output | 1 | Response present, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data, 0 for writes and faulted accesses |
| rsp_gp_fault | output | 1 | Protection fault for this request |
| rsp_db_trap | output | 1 | General-detect trap for this request |
| bp_hit | input | 4 | Breakpoint match strobes |
| step_evt | input | 1 | Single-step strobe |
| task_trap_evt | input | 1 | Task-trap strobe |
| bus_lock_evt | input | 1 | Bus-lock trap strobe |
| task_switch | input | 1 | Task-switch strobe |
| bp_addr | output | 128 | Address registers, breakpoint n at bits 32n+31:32n |
| ctl_word | output | 32 | Current control value |

## Verification
The privilege assertion assumes that no task-switch strobe lands in the same cycle as a faulting access. The stimulus keeps every strobe apart from faulting or trapped requests. The sticky-bit and hit assertions allow a software write in the same cycle, and the bench deliberately pairs a hit with a status write once to test the hit-wins rule. Strobes are driven one cycle wide, on the falling clock edge, and the bench makes no assumption about the length of gaps between requests.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned IDX_W  = 3;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CTRL = 2'd2
  } reg_sel_e;

  localparam logic [IDX_W-1:0] IDX_STAT = 3'd6;
  localparam logic [IDX_W-1:0] IDX_CTRL = 3'd7;

  // status bit positions
  localparam int unsigned ST_BLD = 11;
  localparam int unsigned ST_BD  = 13;
  localparam int unsigned ST_BS  = 14;
  localparam int unsigned ST_BT  = 15;

  // control bit positions
  localparam int unsigned CT_ONE = 10;
  localparam int unsigned CT_GD  = 13;
  localparam int unsigned CT_FLD = 16;
endpackage

// File: rtl/dbg_access_ctl.sv
module dbg_access_ctl
  import dbg_pkg::*;
#(
  parameter int unsigned NUM_BP = 4
) (
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [1:0]       req_cpl,
  input  logic             gd_armed,
  output logic             gp_evt,
  output logic             gd_evt,
  output logic             acc_ok,
  output reg_sel_e         sel,
  output logic [1:0]       addr_num,
  output logic [NUM_BP-1:0] addr_we,
  output logic             stat_we,
  output logic             ctrl_we
);
  logic [IDX_W-1:0] canon_idx;

  // indices 4 and 5 fold onto 6 and 7
  always_comb begin
    canon_idx = req_idx;
    if (req_idx[2]) canon_idx = {2'b11, req_idx[0]};
  end

  always_comb begin
    gp_evt = req_valid && (req_cpl != 2'd0);
    gd_evt = req_valid && (req_cpl == 2'd0) && gd_armed;
    acc_ok = req_valid && (req_cpl == 2'd0) && !gd_armed;
  end

  always_comb begin
    addr_num = canon_idx[1:0];
    if (canon_idx == IDX_STAT)      sel = SEL_STAT;
    else if (canon_idx == IDX_CTRL) sel = SEL_CTRL;
    else                            sel = SEL_ADDR;
  end

  for (genvar i = 0; i < NUM_BP; i++) begin : g_addr_we
    assign addr_we[i] = acc_ok && req_write && (sel == SEL_ADDR) &&
                        (canon_idx[1:0] == i[1:0]);
  end

  assign stat_we = acc_ok && req_write && (sel == SEL_STAT);
  assign ctrl_we = acc_ok && req_write && (sel == SEL_CTRL);
endmodule

// File: rtl/dbg_addr_bank.sv
module dbg_addr_bank
  import dbg_pkg::*;
#(
  parameter int unsigned NUM_BP = 4,
  parameter int unsigned ADDR_W = DATA_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_BP-1:0]        we,
  input  logic [ADDR_W-1:0]        wdata,
  output logic [NUM_BP*ADDR_W-1:0] addr_flat
);
  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    logic [ADDR_W-1:0] addr_q;
    always_ff @(posedge clk) begin
      if (!rst_n)     addr_q <= '0;
      else if (we[i]) addr_q <= wdata;
    end
    assign addr_flat[i*ADDR_W +: ADDR_W] = addr_q;
  end
endmodule

// File: rtl/dbg_status_reg.sv
module dbg_status_reg
  import dbg_pkg::*;
#(
  parameter int unsigned NUM_BP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_BP-1:0] bp_hit,
  input  logic              step_evt,
  input  logic              task_trap_evt,
  input  logic              bus_lock_evt,
  input  logic              gd_evt,
  output logic [DATA_W-1:0] rd
);
  localparam int unsigned ONES_LO = ST_BLD - NUM_BP;

  logic [NUM_BP-1:0] hit_q;
  logic bld_q, bd_q, bs_q, bt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q <= '0;
      bld_q <= 1'b0;
      bd_q  <= 1'b0;
      bs_q  <= 1'b0;
      bt_q  <= 1'b0;
    end else begin
      hit_q <= (we ? wdata[NUM_BP-1:0] : hit_q) | bp_hit;
      bld_q <= bus_lock_evt ? 1'b0 : (we ? wdata[ST_BLD] : bld_q);
      bd_q  <= (we ? wdata[ST_BD] : bd_q) | gd_evt;
      bs_q  <= (we ? wdata[ST_BS] : bs_q) | step_evt;
      bt_q  <= (we ? wdata[ST_BT] : bt_q) | task_trap_evt;
    end
  end

  assign rd = {{(DATA_W-ST_BT-1){1'b1}}, bt_q, bs_q, bd_q, 1'b0, bld_q,
               {ONES_LO{1'b1}}, hit_q};

  // R5
  hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_hit != '0) |=> ((hit_q & $past(bp_hit)) == $past(bp_hit)));

  // R6
  step_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bs_q && !we) |=> bs_q);

  // R6
  ttrap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bt_q && !we) |=> bt_q);

  // R9
  buslock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_lock_evt |=> !bld_q);
endmodule

// File: rtl/dbg_ctrl_reg.sv
module dbg_ctrl_reg
  import dbg_pkg::*;
#(
  parameter int unsigned NUM_BP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              task_sw,
  input  logic              gd_evt,
  output logic [DATA_W-1:0] rd
);
  localparam int unsigned EN_W  = 2*NUM_BP;
  localparam int unsigned FLD_W = 4*NUM_BP;

  logic [EN_W-1:0] keep_mask;
  for (genvar i = 0; i < EN_W; i++) begin : g_mask
    assign keep_mask[i] = (i % 2 == 1);
  end

  logic [EN_W-1:0]  en_q;
  logic [1:0]       exact_q;
  logic             gd_q;
  logic [FLD_W-1:0] fld_q;
  logic [EN_W-1:0]  en_nxt;

  always_comb begin
    en_nxt = we ? wdata[EN_W-1:0] : en_q;
    if (task_sw) en_nxt = en_nxt & keep_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      exact_q <= '0;
      gd_q    <= 1'b0;
      fld_q   <= '0;
    end else begin
      en_q <= en_nxt;
      if (we) begin
        exact_q <= wdata[EN_W+1:EN_W];
        fld_q   <= wdata[CT_FLD +: FLD_W];
      end
      if (gd_evt)  gd_q <= 1'b0;
      else if (we) gd_q <= wdata[CT_GD];
    end
  end

  assign rd = {fld_q, 2'b00, gd_q, 2'b00, 1'b1, exact_q, en_q};

  // R3
  tsw_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    task_sw |=> ((en_q & ~keep_mask) == '0));

  // R3
  tsw_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (task_sw && !we) |=> ((en_q & keep_mask) == ($past(en_q) & keep_mask)));

  // R4
  gd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gd_evt |=> !gd_q);
endmodule

// File: rtl/dbg_regfile.sv
module dbg_regfile
  import dbg_pkg::*;
#(
  parameter int unsigned NUM_BP = 4,
  parameter int unsigned ADDR_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [2:0]               req_idx,
  input  logic [31:0]              req_wdata,
  input  logic [1:0]               req_cpl,
  output logic                     rsp_valid,
  output logic [31:0]              rsp_rdata,
  output logic                     rsp_gp_fault,
  output logic                     rsp_db_trap,
  input  logic [NUM_BP-1:0]        bp_hit,
  input  logic                     step_evt,
  input  logic                     task_trap_evt,
  input  logic                     bus_lock_evt,
  input  logic                     task_switch,
  output logic [NUM_BP*ADDR_W-1:0] bp_addr,
  output logic [31:0]              ctl_word
);
  logic              gp_evt, gd_evt, acc_ok, stat_we, ctrl_we;
  reg_sel_e          sel;
  logic [1:0]        addr_num;
  logic [NUM_BP-1:0] addr_we;
  logic [31:0]       stat_rd, ctrl_rd, rd_mux;

  assign req_ready = 1'b1;

  dbg_access_ctl #(.NUM_BP(NUM_BP)) u_acc (
    .req_valid(req_valid), .req_write(req_write), .req_idx(req_idx),
    .req_cpl(req_cpl), .gd_armed(ctrl_rd[CT_GD]),
    .gp_evt(gp_evt), .gd_evt(gd_evt), .acc_ok(acc_ok), .sel(sel),
    .addr_num(addr_num), .addr_we(addr_we), .stat_we(stat_we),
    .ctrl_we(ctrl_we)
  );

  dbg_addr_bank #(.NUM_BP(NUM_BP), .ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .we(addr_we), .wdata(req_wdata[ADDR_W-1:0]),
    .addr_flat(bp_addr)
  );

  dbg_status_reg #(.NUM_BP(NUM_BP)) u_stat (
    .clk(clk), .rst_n(rst_n), .we(stat_we), .wdata(req_wdata),
    .bp_hit(bp_hit), .step_evt(step_evt), .task_trap_evt(task_trap_evt),
    .bus_lock_evt(bus_lock_evt), .gd_evt(gd_evt), .rd(stat_rd)
  );

  dbg_ctrl_reg #(.NUM_BP(NUM_BP)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(req_wdata),
    .task_sw(task_switch), .gd_evt(gd_evt), .rd(ctrl_rd)
  );

  assign ctl_word = ctrl_rd;

  always_comb begin
    unique case (sel)
      SEL_STAT: rd_mux = stat_rd;
      SEL_CTRL: rd_mux = ctrl_rd;
      default:  rd_mux = 32'(bp_addr[addr_num*ADDR_W +: ADDR_W]);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      rsp_gp_fault <= 1'b0;
      rsp_db_trap  <= 1'b0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_rdata    <= (acc_ok && !req_write) ? rd_mux : '0;
      rsp_gp_fault <= gp_evt;
      rsp_db_trap  <= gd_evt;
    end
  end

  // R1
  gp_nochange_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cpl != 2'd0 && !task_switch) |=>
      ($stable(ctrl_rd) && $stable(bp_addr) && rsp_gp_fault && !rsp_db_trap));

  // R4
  gd_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cpl == 2'd0 && ctrl_rd[CT_GD]) |=>
      (rsp_db_trap && stat_rd[ST_BD] && !ctrl_rd[CT_GD]));

  // R11
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
endmodule

// File: tb/dbg_regfile_test.sv
`timescale 1ns/1ps
module dbg_regfile_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [2:0] req_idx = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0] req_cpl = '0;
  logic req_ready, rsp_valid, rsp_gp_fault, rsp_db_trap;
  logic [31:0] rsp_rdata, ctl_word;
  logic [3:0] bp_hit = '0;
  logic step_evt = 0, task_trap_evt = 0, bus_lock_evt = 0, task_switch = 0;
  logic [127:0] bp_addr;

  int checks = 0, failures = 0;

  typedef struct {
    logic [31:0] d;
    logic gp;
    logic db;
    string req;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  dbg_regfile uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_idx(req_idx), .req_wdata(req_wdata),
    .req_cpl(req_cpl), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_gp_fault(rsp_gp_fault), .rsp_db_trap(rsp_db_trap), .bp_hit(bp_hit),
    .step_evt(step_evt), .task_trap_evt(task_trap_evt),
    .bus_lock_evt(bus_lock_evt), .task_switch(task_switch),
    .bp_addr(bp_addr), .ctl_word(ctl_word)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one request, expected response pushed to scoreboard
  task automatic access(logic w, logic [2:0] idx, logic [31:0] wd,
                        logic [1:0] cpl, logic [31:0] ed, logic egp,
                        logic edb, string req);
    exp_t e;
    e.d = ed; e.gp = egp; e.db = edb; e.req = req;
    sb.push_back(e);
    req_valid = 1; req_write = w; req_idx = idx; req_wdata = wd; req_cpl = cpl;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_wdata = '0; req_cpl = '0;
  endtask

  task automatic rd(logic [2:0] idx, logic [31:0] ed, string req);
    access(1'b0, idx, '0, 2'd0, ed, 1'b0, 1'b0, req);
  endtask

  task automatic wr(logic [2:0] idx, logic [31:0] wd, string req);
    access(1'b1, idx, wd, 2'd0, '0, 1'b0, 1'b0, req);
  endtask

  // monitor: pops and compares responses
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (sb.size() == 0) begin
        failures++;
        $display("FAIL R11 unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (rsp_rdata !== e.d || rsp_gp_fault !== e.gp || rsp_db_trap !== e.db) begin
          failures++;
          $display("FAIL %s actual=%h/gp%b/db%b expected=%h/gp%b/db%b",
                   e.req, rsp_rdata, rsp_gp_fault, rsp_db_trap, e.d, e.gp, e.db);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 ctl_word", ctl_word, 32'h0000_0400);
    chk("R11 ready", {31'd0, req_ready}, 32'd1);
    rd(3'd7, 32'h0000_0400, "R10 ctrl");
    rd(3'd6, 32'hFFFF_07F0, "R10 R8 status");
    rd(3'd0, 32'h0, "R10 addr0");
    rd(3'd3, 32'h0, "R10 addr3");

    // R11 address registers
    for (int i = 0; i < 4; i++) wr(3'(i), 32'hA000_0000 + 32'(i) * 32'h1111_0101, "R11 wr");
    for (int i = 0; i < 4; i++) rd(3'(i), 32'hA000_0000 + 32'(i) * 32'h1111_0101, "R11 rd");
    chk("R11 bp_addr", bp_addr[95:64], 32'hC222_0202);

    // R7 R12 control fixed bits
    wr(3'd7, 32'hFFFF_DFFF, "R7 wr");
    rd(3'd7, 32'hFFFF_07FF, "R7 ctrl");
    chk("R12 ctl_word", ctl_word, 32'hFFFF_07FF);
    // R2 aliases
    rd(3'd5, 32'hFFFF_07FF, "R2 idx5");
    rd(3'd4, 32'hFFFF_07F0, "R2 idx4");

    // R3 task switch clears locals only
    task_switch = 1; @(negedge clk); task_switch = 0;
    rd(3'd7, 32'hFFFF_07AA, "R3 locals");
    // R3 task switch wins over same-cycle write
    task_switch = 1;
    wr(3'd7, 32'h0000_00FF, "R3 wr");
    task_switch = 0;
    chk("R3 ctl_word", ctl_word, 32'h0000_04AA);

    // R12 fields
    wr(3'd5, 32'hA5C3_0003, "R12 R2 wr");
    chk("R12 fields", ctl_word, 32'hA5C3_0403);
    rd(3'd7, 32'hA5C3_0403, "R12 rd");

    // R5 hits sticky
    bp_hit = 4'b0101; @(negedge clk); bp_hit = 0;
    repeat (2) @(negedge clk);
    rd(3'd6, 32'hFFFF_07F5, "R5 hit");
    bp_hit = 4'b0010;
    wr(3'd6, 32'h0, "R5 wr");
    bp_hit = 0;
    rd(3'd6, 32'hFFFF_07F2, "R5 hit wins");

    // R6 step / task trap
    step_evt = 1; @(negedge clk); step_evt = 0;
    task_trap_evt = 1; @(negedge clk); task_trap_evt = 0;
    repeat (3) @(negedge clk);
    rd(3'd6, 32'hFFFF_C7F2, "R6 set");
    wr(3'd4, 32'h0, "R6 R2 clear");
    rd(3'd6, 32'hFFFF_07F0, "R6 clear");

    // R9 bus lock
    wr(3'd6, 32'h0000_0800, "R9 wr");
    rd(3'd6, 32'hFFFF_0FF0, "R9 set");
    bus_lock_evt = 1; @(negedge clk); bus_lock_evt = 0;
    rd(3'd6, 32'hFFFF_07F0, "R9 cleared");
    bus_lock_evt = 1;
    wr(3'd6, 32'h0000_0800, "R9 wr race");
    bus_lock_evt = 0;
    rd(3'd6, 32'hFFFF_07F0, "R9 strobe wins");

    // R8 R6 writable status bits
    wr(3'd6, 32'hFFFF_FFFF, "R8 wr");
    rd(3'd6, 32'hFFFF_EFFF, "R8 R6 status");
    wr(3'd6, 32'h0, "R8 clear");

    // R1 privilege
    access(1'b1, 3'd0, 32'hDEAD_BEEF, 2'd3, '0, 1'b1, 1'b0, "R1 wr cpl3");
    rd(3'd0, 32'hA000_0000, "R1 addr kept");
    access(1'b1, 3'd7, 32'h0, 2'd1, '0, 1'b1, 1'b0, "R1 ctl cpl1");
    chk("R1 ctl kept", ctl_word, 32'hA5C3_0403);
    access(1'b0, 3'd6, '0, 2'd2, '0, 1'b1, 1'b0, "R1 rd cpl2");

    // R4 general detect
    wr(3'd7, 32'h0000_2000, "R4 arm");
    chk("R4 armed", ctl_word, 32'h0000_2400);
    access(1'b0, 3'd0, '0, 2'd3, '0, 1'b1, 1'b0, "R1 R4 priority");
    chk("R1 gd kept", ctl_word, 32'h0000_2400);
    access(1'b1, 3'd1, 32'h1234_5678, 2'd0, '0, 1'b0, 1'b1, "R4 trap");
    chk("R4 disarmed", ctl_word, 32'h0000_0400);
    rd(3'd1, 32'hB111_0101, "R4 no write");
    rd(3'd6, 32'hFFFF_27F0, "R4 status");

    repeat (2) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL R11 missing responses actual=%0d expected=0", sb.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule